// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block runs the descriptor chaining of one DMA channel. Software writes the address of a first command descriptor into a chain pointer register. The unit then reads that descriptor from memory, one 32-bit word per request. It loads the source, destination and byte count into the channel registers and sends a one-cycle start pulse to the data mover. When the mover reports done and chaining is still enabled, the unit fetches the descriptor that the current one links to.

A descriptor is four words at increasing addresses: source, destination, byte count, and link pointer. A link pointer of zero ends the chain. In that case the chain register keeps the address of the last descriptor and chaining switches off, so the next done pulse ends the transfer. A busy flag marks a fetch in progress. Register writes and done pulses that arrive during a fetch have no effect.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, chain-enable, transfer-active, busy, the read request and the start pulse are all low. The chain register always reads bits 2:0 as zero.
- R2: A register write accepted while not busy, whose value with bits 2:0 cleared is nonzero, stores that cleared value and sets both chain-enable and transfer-active. From the idle state it starts a fetch at that address.
- R3: An accepted write whose value with bits 2:0 cleared is zero stores zero and clears chain-enable. Transfer-active keeps its value.
- R4: A fetch issues four read requests at base, base+4, base+8 and base+12, in that order. Each request waits for the previous response. A request holds valid and its address until ready is seen. Responses of any latency are accepted, and busy stays high for the whole fetch.
- R5: The clock edge after the edge that takes the fourth response loads word 0 into source, word 1 into destination and word 2 into byte count. The same edge raises the start pulse for exactly one cycle.
- R6: A link word that is nonzero after clearing bits 2:0 replaces the chain register with that cleared value. Chain-enable stays set.
- R7: A link word that is zero after clearing bits 2:0 leaves the chain register at the current descriptor's address and clears chain-enable.
- R8: A done pulse while a transfer runs starts a fetch at the chain register if chain-enable is set. Otherwise it clears transfer-active and returns the unit to idle.
- R9: Done pulses that arrive while idle or while fetching have no effect.
- R10: Register writes while busy have no effect on the chain register or the status bits.
- R11: When a write and a done pulse coincide during a running transfer, the write is applied first. The done pulse then acts on the updated chain-enable and chain address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Chain register write strobe |
| cfg_wr_data | input | 32 | Chain register write value |
| cfg_busy | output | 1 | Fetch in progress; writes are dropped |
| chain_addr | output | 32 | Chain register readback |
| chain_en | output | 1 | Chaining enabled |
| xfer_active | output | 1 | Transfer sequence active |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Word address of the read |
| rd_rsp_valid | input | 1 | One-cycle read data strobe |
| rd_rsp_data | input | 32 | Read data |
| mover_start | output | 1 | One-cycle start to the data mover |
| mover_done | input | 1 | Data mover finished the current transfer |
| xfer_src | output | 32 | Loaded source address |
| xfer_dst | output | 32 | Loaded destination address |
| xfer_count | output | 32 | Loaded byte count |

## Verification
A register write and a mover done pulse can land in the same cycle while a transfer runs. The write must win, and the done pulse must then act on the freshly written state. The bench provokes this twice. First it writes a new nonzero pointer together with done, and then expects the requests to target the new address rather than the stored link. Then it writes zero together with done, and expects transfer-active to drop and no fetch to start. Both cases, and every other cycle of the run, are judged against a behavioural reference model that the bench steps every clock.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    parameter int WORD_W     = 32;
    parameter int ALIGN_W    = 3;
    parameter int DESC_WORDS = 4;

    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int BYTE_SHIFT = $clog2(WORD_W / 8);

    // position of each field inside a descriptor
    localparam int W_SRC  = 0;
    localparam int W_DST  = 1;
    localparam int W_CNT  = 2;
    localparam int W_NEXT = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {CH_IDLE, CH_FETCH, CH_RUN} ch_state_e;
    typedef enum logic [1:0] {FP_IDLE, FP_REQ, FP_WAIT} fp_state_e;

    function automatic word_t align_mask(input word_t v);
        return {v[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dma_chain_fetch.sv
module dma_chain_fetch
    import dma_chain_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go_i,
    input  word_t                  base_i,
    output logic                   req_valid_o,
    output word_t                  req_addr_o,
    input  logic                   req_ready_i,
    input  logic                   rsp_valid_i,
    input  word_t                  rsp_data_i,
    output word_t [DESC_WORDS-1:0] words_o,
    output logic                   done_o
);
    typedef struct packed {
        fp_state_e              ph;
        logic [IDX_W-1:0]       idx;
        word_t                  base;
        word_t [DESC_WORDS-1:0] words;
        logic                   done;
    } fetch_t;

    fetch_t fetch_d, fetch_q;

    always_comb begin
        fetch_d      = fetch_q;
        fetch_d.done = 1'b0;
        unique case (fetch_q.ph)
            FP_IDLE: begin
                if (go_i) begin
                    fetch_d.ph   = FP_REQ;
                    fetch_d.idx  = '0;
                    fetch_d.base = base_i;
                end
            end
            FP_REQ: begin
                if (req_ready_i) begin
                    fetch_d.ph = FP_WAIT;
                end
            end
            FP_WAIT: begin
                if (rsp_valid_i) begin
                    fetch_d.words[fetch_q.idx] = rsp_data_i;
                    if (fetch_q.idx == IDX_W'(DESC_WORDS - 1)) begin
                        fetch_d.ph   = FP_IDLE;
                        fetch_d.done = 1'b1;
                    end else begin
                        fetch_d.idx = fetch_q.idx + 1'b1;
                        fetch_d.ph  = FP_REQ;
                    end
                end
            end
            default: fetch_d.ph = FP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
        end else begin
            fetch_q <= fetch_d;
        end
    end

    assign req_valid_o = (fetch_q.ph == FP_REQ);
    assign req_addr_o  = fetch_q.base + (word_t'(fetch_q.idx) << BYTE_SHIFT);
    assign words_o     = fetch_q.words;
    assign done_o      = fetch_q.done;
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  word_t                  wr_data_i,
    input  logic                   done_i,
    input  logic                   fetch_done_i,
    input  word_t [DESC_WORDS-1:0] words_i,
    output logic                   busy_o,
    output word_t                  chain_addr_o,
    output logic                   chain_en_o,
    output logic                   xfer_active_o,
    output logic                   go_o,
    output word_t                  go_base_o,
    output logic                   start_o,
    output word_t                  src_o,
    output word_t                  dst_o,
    output word_t                  cnt_o
);
    typedef struct packed {
        ch_state_e st;
        word_t     chain_addr;
        logic      chen;
        logic      xact;
        word_t     src;
        word_t     dst;
        word_t     cnt;
        logic      start;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  wr_ok;
    word_t wr_val;
    word_t link_val;
    logic  go;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.start = 1'b0;
        go           = 1'b0;
        wr_ok        = wr_en_i && (ctrl_q.st != CH_FETCH);
        wr_val       = align_mask(wr_data_i);
        link_val     = align_mask(words_i[W_NEXT]);

        // the write lands first; a done in the same cycle sees its result
        if (wr_ok) begin
            ctrl_d.chain_addr = wr_val;
            if (wr_val != '0) begin
                ctrl_d.chen = 1'b1;
                ctrl_d.xact = 1'b1;
            end else begin
                ctrl_d.chen = 1'b0;
            end
        end

        unique case (ctrl_q.st)
            CH_IDLE: begin
                if (wr_ok && (wr_val != '0)) begin
                    go        = 1'b1;
                    ctrl_d.st = CH_FETCH;
                end
            end
            CH_RUN: begin
                if (done_i) begin
                    if (ctrl_d.chen) begin
                        go        = 1'b1;
                        ctrl_d.st = CH_FETCH;
                    end else begin
                        ctrl_d.xact = 1'b0;
                        ctrl_d.st   = CH_IDLE;
                    end
                end
            end
            CH_FETCH: begin
                if (fetch_done_i) begin
                    ctrl_d.src = words_i[W_SRC];
                    ctrl_d.dst = words_i[W_DST];
                    ctrl_d.cnt = words_i[W_CNT];
                    if (link_val != '0) begin
                        ctrl_d.chain_addr = link_val;
                    end else begin
                        ctrl_d.chen = 1'b0;
                    end
                    ctrl_d.start = 1'b1;
                    ctrl_d.st    = CH_RUN;
                end
            end
            default: ctrl_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o        = (ctrl_q.st == CH_FETCH);
    assign chain_addr_o  = ctrl_q.chain_addr;
    assign chain_en_o    = ctrl_q.chen;
    assign xfer_active_o = ctrl_q.xact;
    assign go_o          = go;
    assign go_base_o     = ctrl_d.chain_addr;
    assign start_o       = ctrl_q.start;
    assign src_o         = ctrl_q.src;
    assign dst_o         = ctrl_q.dst;
    assign cnt_o         = ctrl_q.cnt;
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [WORD_W-1:0] cfg_wr_data,
    output logic              cfg_busy,
    output logic [WORD_W-1:0] chain_addr,
    output logic              chain_en,
    output logic              xfer_active,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [WORD_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [WORD_W-1:0] rd_rsp_data,
    output logic              mover_start,
    input  logic              mover_done,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [WORD_W-1:0] xfer_count
);
    logic                   go;
    word_t                  go_base;
    word_t [DESC_WORDS-1:0] words;
    logic                   fetch_done;

    dma_chain_fetch i_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .base_i      (go_base),
        .req_valid_o (rd_req_valid),
        .req_addr_o  (rd_req_addr),
        .req_ready_i (rd_req_ready),
        .rsp_valid_i (rd_rsp_valid),
        .rsp_data_i  (rd_rsp_data),
        .words_o     (words),
        .done_o      (fetch_done)
    );

    dma_chain_ctrl i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (cfg_wr_en),
        .wr_data_i     (cfg_wr_data),
        .done_i        (mover_done),
        .fetch_done_i  (fetch_done),
        .words_i       (words),
        .busy_o        (cfg_busy),
        .chain_addr_o  (chain_addr),
        .chain_en_o    (chain_en),
        .xfer_active_o (xfer_active),
        .go_o          (go),
        .go_base_o     (go_base),
        .start_o       (mover_start),
        .src_o         (xfer_src),
        .dst_o         (xfer_dst),
        .cnt_o         (xfer_count)
    );
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk
    import dma_chain_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [WORD_W-1:0] cfg_wr_data,
    input logic              cfg_busy,
    input logic [WORD_W-1:0] chain_addr,
    input logic              chain_en,
    input logic              xfer_active,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [WORD_W-1:0] rd_req_addr,
    input logic              mover_start,
    input logic              mover_done
);
    AST_NZ_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_busy && (cfg_wr_data[WORD_W-1:ALIGN_W] != '0)) |=> (chain_en && xfer_active)); // R2
    AST_ZERO_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_busy && (cfg_wr_data[WORD_W-1:ALIGN_W] == '0) && !mover_done)
        |=> (!chain_en && $stable(xfer_active))); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R4
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> cfg_busy); // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mover_start |=> !mover_start); // R5
    AST_START_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mover_start |-> $past(cfg_busy)); // R5
    AST_ACTIVE_DROPS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_active) |-> $past(mover_done)); // R8
    AST_CHAIN_CHANGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chain_addr) |-> ($past(cfg_wr_en && !cfg_busy) || mover_start)); // R10
endmodule

bind dma_chain_seq dma_chain_seq_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_data  (cfg_wr_data),
    .cfg_busy     (cfg_busy),
    .chain_addr   (chain_addr),
    .chain_en     (chain_en),
    .xfer_active  (xfer_active),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .mover_start  (mover_start),
    .mover_done   (mover_done)
);

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        mover_done = 1'b0;
    logic        rd_req_ready = 1'b0;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        cfg_busy, chain_en, xfer_active, rd_req_valid, mover_start;
    logic [31:0] chain_addr, rd_req_addr, xfer_src, xfer_dst, xfer_count;

    dma_chain_seq i_dma_chain_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_busy(cfg_busy), .chain_addr(chain_addr), .chain_en(chain_en),
        .xfer_active(xfer_active), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .mover_start(mover_start), .mover_done(mover_done), .xfer_src(xfer_src),
        .xfer_dst(xfer_dst), .xfer_count(xfer_count)
    );

    logic [31:0] mem [int];
    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model: 0 idle, 1 fetching, 2 running
    int          m_st;
    logic [31:0] m_ca, m_src, m_dst, m_cnt;
    bit          m_chen, m_xact, m_start, m_wait, m_load;
    logic [31:0] aq[$];
    logic [31:0] dq[$];
    bit          wr_ok, take, hs, launch;
    logic [31:0] wv, nx;

    // memory responder
    bit          armed, r_pend;
    int          r_cnt, armed_lat;
    logic [31:0] armed_addr, r_addr;
    logic [7:0]  lfsr = 8'h5A;

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return '0;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ca = '0; m_src = '0; m_dst = '0; m_cnt = '0;
            m_chen = 0; m_xact = 0; m_start = 0; m_wait = 0; m_load = 0;
            aq.delete(); dq.delete();
        end else begin
            take   = rd_rsp_valid && m_wait;
            hs     = (aq.size() > 0) && !m_wait && rd_req_ready;
            wv     = cfg_wr_data & ~32'h7;
            wr_ok  = cfg_wr_en && (m_st != 1);
            launch = 0;
            m_start = 0;
            if (wr_ok) begin
                m_ca = wv;
                if (wv != 0) begin m_chen = 1; m_xact = 1; end
                else m_chen = 0;
            end
            if (m_st == 0) begin
                if (wr_ok && wv != 0) begin launch = 1; m_st = 1; end
            end else if (m_st == 2) begin
                if (mover_done) begin
                    if (m_chen) begin launch = 1; m_st = 1; end
                    else begin m_xact = 0; m_st = 0; end
                end
            end else if (m_load) begin
                m_src = dq[0]; m_dst = dq[1]; m_cnt = dq[2];
                nx = dq[3] & ~32'h7;
                if (nx != 0) m_ca = nx; else m_chen = 0;
                m_start = 1; m_st = 2; m_load = 0;
                dq.delete();
            end
            if (hs) begin void'(aq.pop_front()); m_wait = 1; end
            if (take) begin
                dq.push_back(rd_rsp_data);
                m_wait = 0;
                if (dq.size() == 4) m_load = 1;
            end
            if (launch) for (int i = 0; i < 4; i++) aq.push_back(m_ca + 32'(4 * i));
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R10", "busy", {31'd0, cfg_busy}, {31'd0, m_st == 1});
            check("R1", "chain_addr", chain_addr, m_ca);
            check("R2", "chain_en", {31'd0, chain_en}, {31'd0, m_chen});
            check("R8", "xfer_active", {31'd0, xfer_active}, {31'd0, m_xact});
            check("R5", "start", {31'd0, mover_start}, {31'd0, m_start});
            check("R4", "req_valid", {31'd0, rd_req_valid}, {31'd0, (aq.size() > 0) && !m_wait});
            if ((aq.size() > 0) && !m_wait) check("R4", "req_addr", rd_req_addr, aq[0]);
            check("R5", "src", xfer_src, m_src);
            check("R5", "dst", xfer_dst, m_dst);
            check("R5", "count", xfer_count, m_cnt);
        end
        if (armed) begin
            r_pend = 1; r_cnt = armed_lat; r_addr = armed_addr; armed = 0;
        end
        if (r_pend && r_cnt == 0) begin
            rd_rsp_valid = 1; rd_rsp_data = rd_mem(r_addr); r_pend = 0;
        end else begin
            rd_rsp_valid = 0;
            if (r_pend) r_cnt--;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_req_ready = lfsr[0] | lfsr[2];
        if (rst_n && (aq.size() > 0) && !m_wait && rd_req_ready) begin
            armed = 1; armed_addr = aq[0]; armed_lat = int'(lfsr[5:4]);
        end
        if (cycles > 20000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<20000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [31:0] v, input bit with_done);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_data = v; mover_done = with_done;
        @(negedge clk);
        cfg_wr_en = 0; mover_done = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); mover_done = 1;
        @(negedge clk); mover_done = 0;
    endtask

    task automatic wait_start();
        do @(negedge clk); while (!mover_start);
    endtask

    initial begin
        mem[32'h100] = 32'h1000; mem[32'h104] = 32'h2000; mem[32'h108] = 32'h40;  mem[32'h10C] = 32'h208;
        mem[32'h208] = 32'h1100; mem[32'h20C] = 32'h2100; mem[32'h210] = 32'h80;  mem[32'h214] = 32'h30F;
        mem[32'h308] = 32'h1200; mem[32'h30C] = 32'h2200; mem[32'h310] = 32'hC0;  mem[32'h314] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", "reset chain_en", {31'd0, chain_en}, 32'd0);
        check("R1", "reset xfer_active", {31'd0, xfer_active}, 32'd0);
        check("R1", "reset busy", {31'd0, cfg_busy}, 32'd0);

        wr(32'h5, 0);   // only reserved bits set: counts as zero
        check("R3", "masked zero write chain_addr", chain_addr, 32'h0);
        check("R3", "masked zero write no fetch", {31'd0, cfg_busy}, 32'd0);

        wr(32'h100, 0);
        check("R2", "arm chain_en", {31'd0, chain_en}, 32'd1);
        check("R4", "fetch busy", {31'd0, cfg_busy}, 32'd1);
        wr(32'h999, 1); // dropped write plus done during fetch
        check("R10", "busy write dropped", chain_addr, 32'h100);
        check("R9", "done during fetch ignored", {31'd0, xfer_active}, 32'd1);
        wait_start();
        check("R5", "first src", xfer_src, 32'h1000);
        check("R6", "link taken", chain_addr, 32'h208);
        repeat (3) @(negedge clk);
        pulse_done();
        wait_start();
        check("R6", "link masked", chain_addr, 32'h308);
        pulse_done();
        wait_start();
        check("R7", "null link keeps addr", chain_addr, 32'h308);
        check("R7", "null link clears chain_en", {31'd0, chain_en}, 32'd0);
        repeat (2) @(negedge clk);
        pulse_done();
        check("R8", "final done clears active", {31'd0, xfer_active}, 32'd0);

        wr(32'h100, 0);
        wait_start();
        wr(32'h0, 0);
        check("R3", "zero write keeps active", {31'd0, xfer_active}, 32'd1);
        check("R3", "zero write clears chain_en", {31'd0, chain_en}, 32'd0);
        pulse_done();
        check("R8", "done without chain ends", {31'd0, xfer_active}, 32'd0);

        wr(32'h100, 0);
        wait_start();
        wr(32'h308, 1); // write and done together
        check("R11", "collision fetch starts", {31'd0, cfg_busy}, 32'd1);
        wait_start();
        check("R11", "collision used new pointer", xfer_src, 32'h1200);
        wr(32'h0, 1);
        check("R11", "zero write with done ends", {31'd0, xfer_active}, 32'd0);
        check("R11", "zero write with done no fetch", {31'd0, cfg_busy}, 32'd0);
        pulse_done();
        check("R9", "done while idle ignored", {31'd0, cfg_busy}, 32'd0);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule